// File: doc/BRIEF.md
# Frame Byte Sequencer with CRC-8 and Underflow Poisoning

This block sits between a host and a serial bit transmitter for a J1850-style frame. The host loads one byte at a time into a single holding slot. It writes the data first and then a 2-bit opcode. The opcode says whether the frame is a streamed one, which expects more data, and whether a CRC byte goes out after this byte. The sequencer presents each byte to the bit shifter so that consecutive bytes leave back to back. Alongside, it keeps a CRC-8 over every data byte of the frame, and it can append the complement of that CRC as the closing byte.

A streamed frame may not yet be closed by a CRC request when the shifter finishes the last bit of the current byte. If the slot is still empty at that point, the host has missed its window. The sequencer then closes the frame itself with the bitwise inverse of the correct CRC byte, so every receiver rejects the frame, and it pulses an underflow event for the error logic. Non-streamed transfers, such as single-byte responses, simply end when no further byte is ready. Driving the enable low or the disable high abandons everything and returns the block to idle.

Top module: `j1850_tx_seq`

## Requirements
- R1: After reset `tx_valid` and `uflow_evt` are both low.
- R2: A data write followed, in the same or a later cycle, by an opcode write fills the slot. The byte is then offered on `tx_byte` with `tx_valid` high and `tx_crc_byte` low. Opcode bit 1 = streamed (more data expected), bit 0 = append CRC after this byte.
- R3: From idle, a one-cycle `shf_idle` pulse while a byte is offered starts a frame with that byte. The first byte of a frame is never a CRC byte.
- R4: While a data byte is shifting, a slot filled at least one cycle before the `bit_last` strobe is taken on that strobe, giving adjacent bytes.
- R5: After a byte whose opcode bit 0 is set, the offered byte is the one's complement of the CRC register, with `tx_crc_byte` high. The CRC register is CRC-8, polynomial 1Dh, MSB first, preset to FFh at each frame start, and updated by data bytes only.
- R6: On `bit_last` after a streamed byte with bit 0 clear and an empty slot, the byte sent is the uncomplemented CRC register (the inverse of the correct CRC byte), with `tx_crc_byte` high. `uflow_evt` is high for exactly the one cycle after that strobe cycle.
- R7: A byte with both opcode bits clear and no next byte ready ends the frame on `bit_last` with no underflow and no CRC byte.
- R8: An opcode write with no data written since the slot was last filled or emptied leaves the slot empty.
- R9: An opcode write in the same cycle as `bit_last` is too late for that strobe. Underflow is signalled, and the byte stays in the slot for a later frame.
- R10: `en` low or `dis` high returns the block to idle, empties the slot, and makes the next frame's CRC start from FFh.
- R11: `bit_last` during a CRC byte ends the frame. `tx_valid` stays low until the slot is filled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low aborts |
| dis | input | 1 | Block disable; high aborts |
| host_wr_data | input | 1 | Data write strobe |
| host_data | input | 8 | Data byte |
| host_wr_op | input | 1 | Opcode write strobe |
| host_op | input | 2 | Opcode: bit 1 streamed, bit 0 append CRC |
| shf_idle | input | 1 | Shifter idle and ready to start a frame |
| bit_last | input | 1 | Last bit of current byte completes; shifter takes the next byte |
| tx_valid | output | 1 | A byte is offered to the shifter |
| tx_byte | output | 8 | Offered byte |
| tx_crc_byte | output | 1 | Offered byte is a (good or poisoned) CRC byte that ends the frame |
| uflow_evt | output | 1 | One-cycle host data underflow event |

## Verification
The bench aims at the slot boundary. An opcode raised together with the strobe must count as late. A design that sampled it combinationally would send the data and miss the underflow. The poisoned byte must be the raw register, while a normal close sends its complement. Swapping these, or folding the CRC byte into the running CRC, shows up in the randomized frames, which are compared with a CRC computed byte-wise in the bench. Orphan opcodes, non-streamed single bytes and mid-frame aborts check that no stray frame starts and that the CRC preset is restored.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    localparam int BYTE_W   = 8;
    localparam int CRC_W    = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h1D;
    localparam logic [CRC_W-1:0] CRC_INIT = 8'hFF;

    // bit 1: streamed frame, bit 0: append CRC after this byte
    typedef struct packed {
        logic stream;
        logic add_crc;
    } op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CRC  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        K_NONE    = 2'd0,
        K_DATA    = 2'd1,
        K_CRC_OK  = 2'd2,
        K_CRC_BAD = 2'd3
    } offer_kind_t;

    // One byte through the CRC, most significant bit first.
    function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c,
                                                   input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ d[i])
                r = (r << 1) ^ CRC_POLY;
            else
                r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tsq_slot.sv
module tsq_slot
    import tsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wr_data_val,
    input  logic              wr_op,
    input  op_t               wr_op_val,
    input  logic              consume,
    output logic              full,
    output logic [BYTE_W-1:0] data,
    output op_t               op
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            pend <= 1'b0;
            full <= 1'b0;
            data <= '0;
            op   <= '0;
        end else begin
            if (consume)
                full <= 1'b0;
            if (wr_data) begin
                data <= wr_data_val;
                pend <= 1'b1;
                full <= 1'b0;
            end
            if (wr_op && (pend || wr_data)) begin
                op   <= wr_op_val;
                full <= 1'b1;
                pend <= 1'b0;
            end
        end
    end

    // R8: an opcode alone never fills an empty slot
    a_r8_orphan_op: assert property (@(posedge clk) disable iff (rst)
        (!full && wr_op && !pend && !wr_data && !abort) |=> !full);

endmodule

// File: rtl/tsq_crc.sv
module tsq_crc
    import tsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              upd,
    input  logic              start,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc_q
);

    logic [CRC_W-1:0] base;

    always_comb base = start ? CRC_INIT : crc_q;

    always_ff @(posedge clk) begin
        if (rst || abort)
            crc_q <= CRC_INIT;
        else if (upd)
            crc_q <= crc8_step(base, din);
    end

    // R5: the register moves only on a data byte
    a_r5_crc_hold: assert property (@(posedge clk) disable iff (rst)
        (!upd && !abort) |=> $stable(crc_q));

endmodule

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
    import tsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              shf_idle,
    input  logic              bit_last,
    input  logic              slot_full,
    input  logic [BYTE_W-1:0] slot_data,
    input  op_t               slot_op,
    input  logic [CRC_W-1:0]  crc_q,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_crc_byte,
    output logic              consume,
    output logic              crc_upd,
    output logic              crc_start,
    output logic              uflow_evt
);

    seq_state_t  state;
    op_t         cur_op;
    offer_kind_t kind;
    logic        strobe;
    logic        load;

    always_comb begin
        kind   = K_NONE;
        strobe = 1'b0;
        case (state)
            ST_IDLE: begin
                strobe = shf_idle;
                if (slot_full)
                    kind = K_DATA;
            end
            ST_DATA: begin
                strobe = bit_last;
                if (cur_op.add_crc)
                    kind = K_CRC_OK;
                else if (slot_full)
                    kind = K_DATA;
                else if (cur_op.stream)
                    kind = K_CRC_BAD;
            end
            default: strobe = bit_last;
        endcase
    end

    always_comb begin
        tx_valid    = (kind != K_NONE);
        tx_crc_byte = (kind == K_CRC_OK) || (kind == K_CRC_BAD);
        case (kind)
            K_DATA:   tx_byte = slot_data;
            K_CRC_OK: tx_byte = ~crc_q;
            default:  tx_byte = crc_q;
        endcase
        load      = tx_valid && strobe;
        consume   = load && (kind == K_DATA);
        crc_upd   = consume;
        crc_start = consume && (state == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state     <= ST_IDLE;
            cur_op    <= '0;
            uflow_evt <= 1'b0;
        end else begin
            uflow_evt <= load && (kind == K_CRC_BAD);
            if (load) begin
                if (kind == K_DATA) begin
                    state  <= ST_DATA;
                    cur_op <= slot_op;
                end else begin
                    state <= ST_CRC;
                end
            end else if (strobe && state != ST_IDLE) begin
                state <= ST_IDLE;
            end
        end
    end

    // R6: the underflow event follows a poisoned CRC load
    a_r6_uflow_in_crc: assert property (@(posedge clk) disable iff (rst)
        uflow_evt |-> state == ST_CRC);

    // R6: the event lasts one cycle
    a_r6_uflow_single: assert property (@(posedge clk) disable iff (rst)
        uflow_evt |=> !uflow_evt);

    // R10: abort lands in idle with no pending event
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
        abort |=> (state == ST_IDLE) && !uflow_evt);

    // R11: end of the CRC byte closes the frame
    a_r11_crc_end: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CRC && bit_last && !abort) |=> state == ST_IDLE);

    // R5: a requested CRC is offered next
    a_r5_crc_follows: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && cur_op.add_crc) |-> (tx_valid && tx_crc_byte));

    // R3: a frame never opens with a CRC byte
    a_r3_first_data: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && tx_valid) |-> !tx_crc_byte);

endmodule

// File: rtl/j1850_tx_seq.sv
module j1850_tx_seq
    import tsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              dis,
    input  logic              host_wr_data,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              host_wr_op,
    input  logic [1:0]        host_op,
    input  logic              shf_idle,
    input  logic              bit_last,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_crc_byte,
    output logic              uflow_evt
);

    logic              abort;
    logic              slot_full;
    logic [BYTE_W-1:0] slot_data;
    op_t               slot_op;
    op_t               op_in;
    logic              consume;
    logic              crc_upd;
    logic              crc_start;
    logic [CRC_W-1:0]  crc_q;

    always_comb begin
        abort = !en || dis;
        op_in = op_t'(host_op);
    end

    tsq_slot u_slot (
        .clk         (clk),
        .rst         (rst),
        .abort       (abort),
        .wr_data     (host_wr_data),
        .wr_data_val (host_data),
        .wr_op       (host_wr_op),
        .wr_op_val   (op_in),
        .consume     (consume),
        .full        (slot_full),
        .data        (slot_data),
        .op          (slot_op)
    );

    tsq_crc u_crc (
        .clk   (clk),
        .rst   (rst),
        .abort (abort),
        .upd   (crc_upd),
        .start (crc_start),
        .din   (slot_data),
        .crc_q (crc_q)
    );

    tsq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .abort       (abort),
        .shf_idle    (shf_idle),
        .bit_last    (bit_last),
        .slot_full   (slot_full),
        .slot_data   (slot_data),
        .slot_op     (slot_op),
        .crc_q       (crc_q),
        .tx_valid    (tx_valid),
        .tx_byte     (tx_byte),
        .tx_crc_byte (tx_crc_byte),
        .consume     (consume),
        .crc_upd     (crc_upd),
        .crc_start   (crc_start),
        .uflow_evt   (uflow_evt)
    );

    // R1: quiet after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!tx_valid && !uflow_evt));

endmodule

// File: tb/j1850_tx_seq_test.sv
module j1850_tx_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       dis = 1'b0;
    logic       host_wr_data = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       host_wr_op = 1'b0;
    logic [1:0] host_op = 2'b00;
    logic       shf_idle = 1'b0;
    logic       bit_last = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       tx_crc_byte;
    logic       uflow_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] ecrc;

    always #2 clk = ~clk;

    j1850_tx_seq uut (
        .clk(clk), .rst(rst), .en(en), .dis(dis),
        .host_wr_data(host_wr_data), .host_data(host_data),
        .host_wr_op(host_wr_op), .host_op(host_op),
        .shf_idle(shf_idle), .bit_last(bit_last),
        .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_crc_byte(tx_crc_byte), .uflow_evt(uflow_evt)
    );

    // byte-wise CRC-8, poly 1Dh
    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        repeat (8) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h1D) : {r[6:0], 1'b0};
        return r;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_data_only(input logic [7:0] d);
        host_data = d; host_wr_data = 1'b1;
        @(negedge clk); host_wr_data = 1'b0;
    endtask

    task automatic wr_op_only(input logic [1:0] op);
        host_op = op; host_wr_op = 1'b1;
        @(negedge clk); host_wr_op = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] d, input logic [1:0] op);
        wr_data_only(d);
        wr_op_only(op);
    endtask

    task automatic pulse_idle();
        shf_idle = 1'b1; @(negedge clk); shf_idle = 1'b0;
    endtask

    task automatic pulse_last();
        bit_last = 1'b1; @(negedge clk); bit_last = 1'b0;
    endtask

    task automatic abort_cycle();
        en = 1'b0; @(negedge clk); en = 1'b1;
    endtask

    // mode 0: closes with CRC request, mode 1: host underflow
    task automatic run_frame(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            logic [1:0] op;
            d  = 8'($urandom);
            op = {1'b1, (mode == 0 && i == n - 1)};
            repeat ($urandom % 3) @(negedge clk);
            write_byte(d, op);
            chk("R2 valid", {7'd0, tx_valid}, 8'd1);
            chk("R4 data byte", tx_byte, d);
            chk("R2 not crc", {7'd0, tx_crc_byte}, 8'd0);
            ecrc = crc_byte((i == 0) ? 8'hFF : ecrc, d);
            if (i == 0) pulse_idle(); else pulse_last();
            chk("R4 no uflow", {7'd0, uflow_evt}, 8'd0);
        end
        if (mode == 0) begin
            chk("R5 crc byte", tx_byte, ~ecrc);
            chk("R5 crc flag", {6'd0, tx_valid, tx_crc_byte}, 8'd3);
            pulse_last();
            chk("R5 no uflow", {7'd0, uflow_evt}, 8'd0);
        end else begin
            chk("R6 poisoned byte", tx_byte, ecrc);
            chk("R6 crc flag", {6'd0, tx_valid, tx_crc_byte}, 8'd3);
            pulse_last();
            chk("R6 uflow pulse", {7'd0, uflow_evt}, 8'd1);
            @(negedge clk);
            chk("R6 uflow single", {7'd0, uflow_evt}, 8'd0);
        end
        chk("R11 quiet in crc", {7'd0, tx_valid}, 8'd0);
        pulse_last();
        chk("R11 idle after frame", {7'd0, tx_valid}, 8'd0);
    endtask

    initial begin
        void'($urandom(32'd1850));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 valid low", {7'd0, tx_valid}, 8'd0);
        chk("R1 uflow low", {7'd0, uflow_evt}, 8'd0);

        // R8: opcode alone
        wr_op_only(2'b11);
        @(negedge clk);
        chk("R8 orphan op", {7'd0, tx_valid}, 8'd0);
        pulse_idle();
        chk("R8 no frame", {7'd0, tx_valid}, 8'd0);

        // R3/R5: single-byte frame with CRC, known value
        write_byte(8'h00, 2'b11);
        chk("R3 first byte", tx_byte, 8'h00);
        chk("R3 first not crc", {7'd0, tx_crc_byte}, 8'd0);
        pulse_idle();
        chk("R5 crc of 00", tx_byte, ~crc_byte(8'hFF, 8'h00));

        pulse_last();
        pulse_last();

        // R7: non-streamed single byte, no next byte
        write_byte(8'h5A, 2'b00);
        pulse_idle();
        chk("R7 nothing offered", {7'd0, tx_valid}, 8'd0);
        pulse_last();
        chk("R7 no uflow", {7'd0, uflow_evt}, 8'd0);
        chk("R7 idle", {7'd0, tx_valid}, 8'd0);

        // R9: opcode in strobe cycle is late
        write_byte(8'h11, 2'b10);
        pulse_idle();
        ecrc = crc_byte(8'hFF, 8'h11);
        wr_data_only(8'h22);
        host_op = 2'b11; host_wr_op = 1'b1; bit_last = 1'b1;
        @(negedge clk);
        host_wr_op = 1'b0; bit_last = 1'b0;
        chk("R9 late uflow", {7'd0, uflow_evt}, 8'd1);
        pulse_last();
        chk("R9 byte kept", tx_byte, 8'h22);
        chk("R9 byte kept valid", {7'd0, tx_valid}, 8'd1);

        // R10: abort clears slot and CRC
        abort_cycle();
        chk("R10 slot cleared", {7'd0, tx_valid}, 8'd0);
        write_byte(8'hA5, 2'b10);
        pulse_idle();
        write_byte(8'h3C, 2'b10);
        dis = 1'b1; @(negedge clk); dis = 1'b0;
        chk("R10 dis aborts", {7'd0, tx_valid}, 8'd0);
        write_byte(8'h77, 2'b11);
        pulse_idle();
        chk("R10 crc restarts", tx_byte, ~crc_byte(8'hFF, 8'h77));
        pulse_last();
        pulse_last();

        // randomized frames
        for (int f = 0; f < 24; f++)
            run_frame(1 + ($urandom % 4), $urandom % 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule